// File: doc/BRIEF.md
# OLED Power-Up Sequencer with Command Link

This block brings a small 128 × 32 monochrome OLED module from cold to lit. A single-cycle pulse on `start_i` launches a fixed timed order: the logic rail is switched on, a settle time elapses, the controller's reset line is pulled low for a minimum width, a set of configuration bytes goes out over a write-only four-wire SPI link, the panel rail is switched on and allowed to settle, and finally a display-on byte is sent before `disp_ready` is raised.

All delays come from one shared down-counter whose load values are derived from the clock-frequency parameter and the microsecond delay parameters. The configuration bytes live in a small on-chip table; how many of them are sent is a parameter. Both supply enables and the reset are active-low. The whole path rests in a safe, unpowered state while the block is held in reset.

The sequencer is a nine-state machine. ST_IDLE goes to ST_VDD_WAIT when it sees start. ST_VDD_WAIT goes to ST_RST_PULSE when the timer expires. ST_RST_PULSE goes to ST_INIT_CMD when the timer expires. ST_INIT_CMD launches a byte and goes to ST_INIT_WAIT. When a byte completes, ST_INIT_WAIT returns to ST_INIT_CMD; after the last table byte it goes to ST_VBAT_WAIT instead. ST_VBAT_WAIT goes to ST_ON_CMD when the timer expires. ST_ON_CMD launches the display-on byte and goes to ST_ON_WAIT. When that byte completes, ST_ON_WAIT goes to ST_READY. ST_READY holds until reset.

Top module: `oled_pwr_seq`

## Requirements
- R1: While `rst_n` is low, and in idle until `start_i` is seen, the outputs hold the safe state: `logic_pwr_n`=1, `panel_pwr_n`=1, `disp_rst_n`=1, `spi_cs_n`=1, `spi_sclk`=0, `spi_dc`=1, `disp_ready`=0.
- R2: A high `start_i` in idle drives `logic_pwr_n` low on the following clock. `start_i` has no effect in any state other than idle.
- R3: `logic_pwr_n` stays low for exactly VDD_CYC = T_VDD_US·CLK_HZ/10^6 clocks before `disp_rst_n` falls.
- R4: `disp_rst_n` is low for exactly RST_CYC = T_RST_US·CLK_HZ/10^6 clocks. It then stays high for the rest of the sequence and in ready.
- R5: After the reset pulse and before `panel_pwr_n` falls, exactly NUM_INIT bytes are sent. They are the first NUM_INIT entries of the table AE, D5, 80, A8, 1F, 8D, 14, DA, 02 (hex), in that order.
- R6: The SPI link is mode 0, MSB first. `spi_sclk` is low whenever `spi_cs_n` is high. `spi_mosi` does not change while `spi_sclk` is high. Each `spi_cs_n` low window carries exactly 8 rising clock edges. `spi_cs_n` stays high for at least 2 clocks between bytes.
- R7: `spi_dc` is low (command) whenever `spi_cs_n` is low. It is high in idle and ready.
- R8: `panel_pwr_n` falls only after the last table byte has finished. The display-on byte AF begins (`spi_cs_n` falls) between VBAT_CYC and VBAT_CYC+2 clocks after `panel_pwr_n` falls.
- R9: `disp_ready` rises 1 to 3 clocks after the display-on byte's `spi_cs_n` release. It then stays high with both rails on, and no further bytes are sent, until reset.
- R10: Pulling `rst_n` low mid-sequence returns every output to the R1 safe state at once, without waiting for a clock edge. A new start then runs the full sequence again.
- R11: The reset line is low, or the panel rail is on, only while the logic rail is on. The panel rail is on only while the reset line is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (CLK_HZ) |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin the power-up sequence (sampled in idle) |
| logic_pwr_n | output | 1 | Logic supply enable, active low |
| panel_pwr_n | output | 1 | Panel supply enable, active low |
| disp_rst_n | output | 1 | Display controller reset, active low |
| spi_sclk | output | 1 | SPI clock, idle low |
| spi_mosi | output | 1 | SPI data, MSB first |
| spi_cs_n | output | 1 | SPI chip select, active low, one window per byte |
| spi_dc | output | 1 | Data/command select, low = command |
| disp_ready | output | 1 | Display is powered and switched on |

## Verification
A wrong state or an off-by-one timer load shows up at the ports within a single step of the sequence. The rail-to-reset and reset-width intervals are measured to the exact clock. The display-on byte's start is checked against a window two clocks wide. The configuration stream is rebuilt bit by bit from SCLK rising edges and compared against the table, so a skipped or repeated index appears as a wrong byte or a wrong count before the panel rail turns on. Rail-ordering faults and a D/C line left high during a byte are flagged in the clock in which they occur.

// File: rtl/oled_seq_pkg.sv
package oled_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_VDD_WAIT,
        ST_RST_PULSE,
        ST_INIT_CMD,
        ST_INIT_WAIT,
        ST_VBAT_WAIT,
        ST_ON_CMD,
        ST_ON_WAIT,
        ST_READY
    } seq_state_e;

    localparam int CFG_TABLE_LEN = 9;
    localparam logic [7:0] CFG_FILL = 8'hE3;

    // Configuration table: display off, clock divide, mux ratio for
    // 32 rows, charge pump on, COM pin layout for a 32-row panel.
    function automatic logic [7:0] cfg_byte(input int unsigned idx);
        logic [7:0] b;
        case (idx)
            0:       b = 8'hAE;
            1:       b = 8'hD5;
            2:       b = 8'h80;
            3:       b = 8'hA8;
            4:       b = 8'h1F;
            5:       b = 8'h8D;
            6:       b = 8'h14;
            7:       b = 8'hDA;
            8:       b = 8'h02;
            default: b = CFG_FILL;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/oled_wait_timer.sv
module oled_wait_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/oled_cfg_rom.sv
module oled_cfg_rom
    import oled_seq_pkg::*;
#(
    parameter int IW = 4
) (
    input  logic [IW-1:0] idx,
    output logic [7:0]    cmd_o
);
    always_comb begin
        cmd_o = cfg_byte(32'(idx));
    end
endmodule

// File: rtl/oled_spi_tx.sv
module oled_spi_tx #(
    parameter int HALF = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] data,
    output logic       sclk,
    output logic       mosi,
    output logic       cs_n,
    output logic       done
);
    localparam int DW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [DW-1:0] DIV_RELOAD = DW'(HALF - 1);

    logic [7:0]    shreg;
    logic [2:0]    bit_cnt;
    logic [DW-1:0] div_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n    <= 1'b1;
            sclk    <= 1'b0;
            shreg   <= '0;
            bit_cnt <= '0;
            div_cnt <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (cs_n) begin
                if (go) begin
                    cs_n    <= 1'b0;
                    sclk    <= 1'b0;
                    shreg   <= data;
                    bit_cnt <= '0;
                    div_cnt <= DIV_RELOAD;
                end
            end else if (div_cnt != '0) begin
                div_cnt <= div_cnt - 1'b1;
            end else begin
                div_cnt <= DIV_RELOAD;
                if (!sclk) begin
                    sclk <= 1'b1;
                end else begin
                    sclk <= 1'b0;
                    if (bit_cnt == 3'd7) begin
                        cs_n <= 1'b1;
                        done <= 1'b1;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                        shreg   <= {shreg[6:0], 1'b0};
                    end
                end
            end
        end
    end

    assign mosi = shreg[7];
endmodule

// File: rtl/oled_pwr_seq.sv
module oled_pwr_seq
    import oled_seq_pkg::*;
#(
    parameter int         CLK_HZ    = 100_000_000,
    parameter int         T_VDD_US  = 1000,
    parameter int         T_RST_US  = 3,
    parameter int         T_VBAT_US = 100_000,
    parameter int         NUM_INIT  = 9,
    parameter int         SCK_HALF  = 5,
    parameter logic [7:0] ON_CMD    = 8'hAF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic logic_pwr_n,
    output logic panel_pwr_n,
    output logic disp_rst_n,
    output logic spi_sclk,
    output logic spi_mosi,
    output logic spi_cs_n,
    output logic spi_dc,
    output logic disp_ready
);
    localparam int CYC_PER_US = CLK_HZ / 1_000_000;
    localparam int VDD_CYC    = T_VDD_US * CYC_PER_US;
    localparam int RST_CYC    = T_RST_US * CYC_PER_US;
    localparam int VBAT_CYC   = T_VBAT_US * CYC_PER_US;
    localparam int TMAX       = (VBAT_CYC > VDD_CYC) ?
                                ((VBAT_CYC > RST_CYC) ? VBAT_CYC : RST_CYC) :
                                ((VDD_CYC > RST_CYC) ? VDD_CYC : RST_CYC);
    localparam int TW         = $clog2(TMAX + 1);
    localparam int IW         = (NUM_INIT > 1) ? $clog2(NUM_INIT) : 1;
    localparam logic [IW-1:0] LAST_IDX = IW'(NUM_INIT - 1);

    seq_state_e    state, nxt;
    logic          tmr_load, tmr_done;
    logic [TW-1:0] tmr_val;
    logic [IW-1:0] idx;
    logic          idx_clr, idx_inc;
    logic          spi_go, spi_done;
    logic [7:0]    rom_byte, tx_byte;

    oled_wait_timer #(.W(TW)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    oled_cfg_rom #(.IW(IW)) u_rom (
        .idx   (idx),
        .cmd_o (rom_byte)
    );

    assign tx_byte = (state == ST_ON_CMD) ? ON_CMD : rom_byte;

    oled_spi_tx #(.HALF(SCK_HALF)) u_spi (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (spi_go),
        .data  (tx_byte),
        .sclk  (spi_sclk),
        .mosi  (spi_mosi),
        .cs_n  (spi_cs_n),
        .done  (spi_done)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Table index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (idx_clr) begin
            idx <= '0;
        end else if (idx_inc) begin
            idx <= idx + 1'b1;
        end
    end

    // Next state and timer loads
    always_comb begin
        nxt      = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        idx_clr  = 1'b0;
        idx_inc  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start_i) begin
                    nxt      = ST_VDD_WAIT;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(VDD_CYC - 1);
                end
            end
            ST_VDD_WAIT: begin
                if (tmr_done) begin
                    nxt      = ST_RST_PULSE;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(RST_CYC - 1);
                end
            end
            ST_RST_PULSE: begin
                if (tmr_done) begin
                    nxt     = ST_INIT_CMD;
                    idx_clr = 1'b1;
                end
            end
            ST_INIT_CMD: begin
                nxt = ST_INIT_WAIT;
            end
            ST_INIT_WAIT: begin
                if (spi_done) begin
                    if (idx == LAST_IDX) begin
                        nxt      = ST_VBAT_WAIT;
                        tmr_load = 1'b1;
                        tmr_val  = TW'(VBAT_CYC - 1);
                    end else begin
                        nxt     = ST_INIT_CMD;
                        idx_inc = 1'b1;
                    end
                end
            end
            ST_VBAT_WAIT: begin
                if (tmr_done) begin
                    nxt = ST_ON_CMD;
                end
            end
            ST_ON_CMD: begin
                nxt = ST_ON_WAIT;
            end
            ST_ON_WAIT: begin
                if (spi_done) begin
                    nxt = ST_READY;
                end
            end
            ST_READY: begin
                nxt = ST_READY;
            end
            default: begin
                nxt = ST_IDLE;
            end
        endcase
    end

    // Outputs decoded from the state register
    always_comb begin
        logic_pwr_n = 1'b0;
        panel_pwr_n = 1'b1;
        disp_rst_n  = 1'b1;
        spi_dc      = 1'b0;
        disp_ready  = 1'b0;
        spi_go      = 1'b0;
        unique case (state)
            ST_IDLE: begin
                logic_pwr_n = 1'b1;
                spi_dc      = 1'b1;
            end
            ST_VDD_WAIT: begin
            end
            ST_RST_PULSE: begin
                disp_rst_n = 1'b0;
            end
            ST_INIT_CMD: begin
                spi_go = 1'b1;
            end
            ST_INIT_WAIT: begin
            end
            ST_VBAT_WAIT: begin
                panel_pwr_n = 1'b0;
            end
            ST_ON_CMD: begin
                panel_pwr_n = 1'b0;
                spi_go      = 1'b1;
            end
            ST_ON_WAIT: begin
                panel_pwr_n = 1'b0;
            end
            ST_READY: begin
                panel_pwr_n = 1'b0;
                spi_dc      = 1'b1;
                disp_ready  = 1'b1;
            end
            default: begin
                logic_pwr_n = 1'b1;
                spi_dc      = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/oled_seq_chk.sv
module oled_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic logic_pwr_n,
    input logic panel_pwr_n,
    input logic disp_rst_n,
    input logic spi_sclk,
    input logic spi_mosi,
    input logic spi_cs_n,
    input logic spi_dc,
    input logic disp_ready
);
    // R7
    dc_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_cs_n |-> !spi_dc);

    // R6
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);

    // R6
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

    // R11
    rst_rail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_rst_n |-> !logic_pwr_n);

    // R11
    panel_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !panel_pwr_n |-> (!logic_pwr_n && disp_rst_n));

    // R8
    panel_after_cmds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(panel_pwr_n) |-> spi_cs_n);

    // R9
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_ready |=> disp_ready);

    // R9
    ready_rails_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_ready |-> (!logic_pwr_n && !panel_pwr_n && disp_rst_n && spi_cs_n));
endmodule

bind oled_pwr_seq oled_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .logic_pwr_n (logic_pwr_n),
    .panel_pwr_n (panel_pwr_n),
    .disp_rst_n  (disp_rst_n),
    .spi_sclk    (spi_sclk),
    .spi_mosi    (spi_mosi),
    .spi_cs_n    (spi_cs_n),
    .spi_dc      (spi_dc),
    .disp_ready  (disp_ready)
);

// File: tb/sim_oled_pwr_seq.sv
`timescale 1ns/1ps
module sim_oled_pwr_seq;
    localparam int CLK_HZ    = 4_000_000;
    localparam int T_VDD_US  = 10;
    localparam int T_RST_US  = 3;
    localparam int T_VBAT_US = 25;
    localparam int NUM_INIT  = 9;
    localparam int SCK_HALF  = 2;
    localparam int CPU       = CLK_HZ / 1_000_000;
    localparam int VDD_CYC   = T_VDD_US * CPU;
    localparam int RST_CYC   = T_RST_US * CPU;
    localparam int VBAT_CYC  = T_VBAT_US * CPU;
    localparam int NB        = NUM_INIT + 1;

    localparam logic [7:0] EXP_BYTES [0:NB-1] = '{
        8'hAE, 8'hD5, 8'h80, 8'hA8, 8'h1F, 8'h8D, 8'h14, 8'hDA, 8'h02, 8'hAF
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic logic_pwr_n, panel_pwr_n, disp_rst_n;
    logic spi_sclk, spi_mosi, spi_cs_n, spi_dc, disp_ready;

    always #2 clk = ~clk;

    oled_pwr_seq #(
        .CLK_HZ(CLK_HZ), .T_VDD_US(T_VDD_US), .T_RST_US(T_RST_US),
        .T_VBAT_US(T_VBAT_US), .NUM_INIT(NUM_INIT), .SCK_HALF(SCK_HALF),
        .ON_CMD(8'hAF)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .logic_pwr_n(logic_pwr_n), .panel_pwr_n(panel_pwr_n),
        .disp_rst_n(disp_rst_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_cs_n(spi_cs_n), .spi_dc(spi_dc), .disp_ready(disp_ready)
    );

    int total = 0;
    int bad = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Port monitor
    logic mon_clr = 1'b1;
    int cyc = 0;
    int f_vdd, f_res, r_res, f_vbat, r_rdy, ncs, nbits, bad_bits, bad_dc, bad_mosi, bad_ord;
    int cs_fall [0:31];
    int cs_rise [0:31];
    logic [7:0] rx [0:31];
    logic [7:0] shv;
    logic p_vdd, p_res, p_vbat, p_cs, p_sclk, p_rdy, p_mosi;

    always @(negedge clk) begin
        cyc++;
        if (mon_clr) begin
            f_vdd = -1; f_res = -1; r_res = -1; f_vbat = -1; r_rdy = -1;
            ncs = 0; nbits = 0; bad_bits = 0; bad_dc = 0; bad_mosi = 0; bad_ord = 0;
            shv = '0;
        end else begin
            if (p_vdd && !logic_pwr_n && f_vdd < 0) f_vdd = cyc;
            if (p_res && !disp_rst_n && f_res < 0) f_res = cyc;
            if (!p_res && disp_rst_n && f_res >= 0 && r_res < 0) r_res = cyc;
            if (p_vbat && !panel_pwr_n && f_vbat < 0) f_vbat = cyc;
            if (!p_rdy && disp_ready && r_rdy < 0) r_rdy = cyc;
            if (p_cs && !spi_cs_n) begin
                if (ncs < 32) cs_fall[ncs] = cyc;
                nbits = 0;
                shv = '0;
            end
            if (!spi_cs_n && !p_sclk && spi_sclk) begin
                shv = {shv[6:0], spi_mosi};
                nbits++;
            end
            if (!spi_cs_n && spi_dc) bad_dc++;
            if (!spi_cs_n && p_sclk && spi_sclk && (spi_mosi != p_mosi)) bad_mosi++;
            if (spi_cs_n && spi_sclk) bad_bits++;
            if (!p_cs && spi_cs_n) begin
                if (nbits != 8) bad_bits++;
                if (ncs < 32) begin
                    cs_rise[ncs] = cyc;
                    rx[ncs] = shv;
                end
                ncs++;
            end
            if (!disp_rst_n && logic_pwr_n) bad_ord++;
            if (!panel_pwr_n && (logic_pwr_n || !disp_rst_n)) bad_ord++;
        end
        p_vdd = logic_pwr_n; p_res = disp_rst_n; p_vbat = panel_pwr_n;
        p_cs = spi_cs_n; p_sclk = spi_sclk; p_rdy = disp_ready; p_mosi = spi_mosi;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    function automatic bit safe_state();
        return logic_pwr_n && panel_pwr_n && disp_rst_n && spi_cs_n &&
               !spi_sclk && spi_dc && !disp_ready;
    endfunction

    task automatic pulse_start(output int t);
        @(negedge clk); #1;
        start_i = 1'b1;
        t = cyc;
        @(negedge clk); #1;
        start_i = 1'b0;
    endtask

    task automatic wait_ready();
        for (int k = 0; k < 5000 && !disp_ready; k++) @(negedge clk);
        #1;
    endtask

    task automatic check_stream(input string tag);
        chk(ncs == NB, {tag, " byte count"}, ncs, NB);
        for (int i = 0; i < NB; i++) begin
            if (i < ncs) chk(rx[i] == EXP_BYTES[i], tag, int'(rx[i]), int'(EXP_BYTES[i]));
        end
    endtask

    initial begin
        int t0, t1, min_gap;
        // R1: reset state
        repeat (3) @(negedge clk);
        #1;
        chk(safe_state(), "R1 reset", 0, 1);
        rst_n = 1'b1;
        @(negedge clk); #1;
        mon_clr = 1'b0;
        repeat (10) @(negedge clk);
        #1;
        chk(safe_state(), "R1 idle without start", 0, 1);

        // Run 1
        pulse_start(t0);
        chk(f_vdd == t0 + 1, "R2 rail on after start", f_vdd, t0 + 1);
        // R2: a second start during the rail wait must not restart timing
        repeat (5) @(negedge clk);
        #1; start_i = 1'b1;
        @(negedge clk); #1; start_i = 1'b0;
        wait_ready();
        chk(disp_ready == 1'b1, "R9 ready reached", int'(disp_ready), 1);
        chk(f_res - f_vdd == VDD_CYC, "R3 rail settle", f_res - f_vdd, VDD_CYC);
        chk(r_res - f_res == RST_CYC, "R4 reset width", r_res - f_res, RST_CYC);
        chk(disp_rst_n == 1'b1, "R4 reset high in ready", int'(disp_rst_n), 1);
        // Table walk: expected byte vector
        check_stream("R5 stream");
        chk(cs_fall[0] > r_res, "R5 first byte after reset", cs_fall[0], r_res + 1);
        chk(cs_rise[NUM_INIT-1] <= f_vbat, "R8 panel after last cfg", cs_rise[NUM_INIT-1], f_vbat);
        chk(rx[NUM_INIT] == 8'hAF, "R8 display-on byte", int'(rx[NUM_INIT]), 'hAF);
        chk(cs_fall[NUM_INIT] - f_vbat >= VBAT_CYC && cs_fall[NUM_INIT] - f_vbat <= VBAT_CYC + 2,
            "R8 panel settle", cs_fall[NUM_INIT] - f_vbat, VBAT_CYC + 1);
        chk(bad_bits == 0, "R6 clock idle and 8 edges", bad_bits, 0);
        chk(bad_mosi == 0, "R6 mosi stable while sclk high", bad_mosi, 0);
        min_gap = 1000;
        for (int i = 1; i < NB; i++) begin
            if (cs_fall[i] - cs_rise[i-1] < min_gap) min_gap = cs_fall[i] - cs_rise[i-1];
        end
        chk(min_gap >= 2, "R6 cs gap", min_gap, 2);
        chk(bad_dc == 0, "R7 dc low during bytes", bad_dc, 0);
        chk(spi_dc == 1'b1, "R7 dc high in ready", int'(spi_dc), 1);
        chk(r_rdy - cs_rise[NUM_INIT] >= 1 && r_rdy - cs_rise[NUM_INIT] <= 3,
            "R9 ready after last byte", r_rdy - cs_rise[NUM_INIT], 1);
        chk(bad_ord == 0, "R11 rail ordering", bad_ord, 0);

        // R9: start in ready has no effect
        pulse_start(t1);
        repeat (60) @(negedge clk);
        #1;
        chk(ncs == NB, "R9 no bytes after ready", ncs, NB);
        chk(disp_ready && !panel_pwr_n && !logic_pwr_n, "R9 ready held", int'(disp_ready), 1);

        // R10: reset mid-sequence
        rst_n = 1'b0;
        mon_clr = 1'b1;
        @(negedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk); #1;
        mon_clr = 1'b0;
        pulse_start(t0);
        for (int k = 0; k < 2000 && ncs < 3; k++) @(negedge clk);
        #1;
        rst_n = 1'b0;
        #1;
        chk(safe_state(), "R10 async return to safe", 0, 1);
        mon_clr = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        chk(safe_state(), "R10 held safe in reset", 0, 1);
        rst_n = 1'b1;
        @(negedge clk); #1;
        mon_clr = 1'b0;
        pulse_start(t0);
        wait_ready();
        check_stream("R10 rerun stream");
        chk(f_res - f_vdd == VDD_CYC, "R10 rerun rail settle", f_res - f_vdd, VDD_CYC);
        chk(bad_ord == 0 && bad_dc == 0, "R11 rerun ordering", bad_ord + bad_dc, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule